// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block sits between a word-transfer arbiter and the serial shift engine of an SPI master. For every word it receives, it drives the chip-select line chosen by that word's code and times three delays, each measured in module clock cycles: a setup delay before the shift engine starts, a hold delay after the engine reports completion, and an optional wait delay between words. It then tells the shift engine when to start. Each word carries three flags. The hold flag keeps the line asserted into the next word, so the hold delay and the following setup delay are skipped while the wait delay still applies. The wait flag inserts the wait delay. The lock flag reserves the sequencer for the word's group so that no other group can cut in.

Words are offered on a request port together with a group number. The block accepts a word with a one-cycle `req_take`. It refuses words from other groups while a locked or held sequence is open. `lock_active` and `lock_owner` report which group currently owns the sequencer, so the arbiter can present that group's next word.

The state machine has seven states: IDLE (no line asserted, waiting for a word), SETUP (line asserted, setup count running), START (one-cycle start pulse), XFER (waiting for the engine's done), HOLD (line still asserted, hold count running), WAIT (wait count running, line held or released per the word) and PARK (line held, waiting for the next word). Its transitions are:
- IDLE→SETUP or IDLE→START when a word is taken, depending on whether the setup count is non-zero.
- SETUP→START when the setup count runs out, and START→XFER unconditionally.
- From XFER on done, a held word goes to WAIT or PARK; an unheld word goes to HOLD, WAIT or IDLE.
- HOLD→WAIT or HOLD→IDLE, and WAIT→PARK or WAIT→IDLE.
- PARK→START when a word with the same code is taken. PARK→HOLD, or PARK→IDLE when the hold count is zero, when the owner offers a word with a different code.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset all `cs_n` bits are 1, `sh_start`, `req_take` and `lock_active` are 0.
- R2: A word taken from IDLE drives `cs_n[code]` low, all other bits high, for exactly `cfg_setup` cycles before `sh_start`; `sh_start` is a single-cycle pulse and is high only while a line is low.
- R3: After `sh_done` for a word whose hold flag is clear, its line stays low for exactly `cfg_hold` cycles and then goes high.
- R4: After `sh_done` for a word whose hold flag is set, its line stays low with no hold delay; the next word with the same code gets `sh_start` in the cycle after it is taken, with no setup delay.
- R5: When a word's wait flag is set, `cfg_wait` cycles pass, after its hold delay or right after done if held, before the next word can be taken; the line is low during these cycles only if the word was held. When the wait flag is clear, `cfg_wait` has no effect.
- R6: After a word with lock or hold set from group g is taken, words from other groups are not taken and no line changes until a word of group g is taken.
- R7: The lock flag alone does not keep the line asserted: a locked word with the hold flag clear releases its line after its hold delay.
- R8: When the line is held and the owner offers a word with a different code, the held line gets `cfg_hold` cycles of hold delay and is released, then the new word is taken from IDLE with its setup delay.
- R9: A count of zero in `cfg_setup`, `cfg_hold` or `cfg_wait` gives no delay cycles for that delay.
- R10: `lock_active` equals the lock-or-hold flag of the last taken word, and `lock_owner` equals that word's group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A word is offered |
| req_grp | input | GRP_W | Group of the offered word |
| req_cs | input | CSW | Chip-select code of the offered word |
| req_hold | input | 1 | Keep the line asserted after this word |
| req_wdel | input | 1 | Insert the wait delay after this word |
| req_lock | input | 1 | Reserve the sequencer for this group after this word |
| req_take | output | 1 | The offered word is accepted on this clock edge |
| sh_start | output | 1 | One-cycle start pulse to the shift engine |
| sh_done | input | 1 | Shift engine finished the current word |
| cs_n | output | NUM_CS | Active-low chip-select lines |
| cfg_setup | input | DLY_W | Setup delay in cycles |
| cfg_hold | input | DLY_W | Hold delay in cycles |
| cfg_wait | input | DLY_W | Wait delay in cycles |
| lock_active | output | 1 | A group owns the sequencer |
| lock_owner | output | GRP_W | Owning group |

## Verification
A wrong state or a misloaded delay counter shows on `cs_n` within one cycle of the faulty transition. The result is a setup or hold window that is one or more cycles too long or too short, or a `sh_start` pulse in the wrong cycle. A wrong held-state decision shows in the first cycle after `sh_done`, as a line that rises when it should stay low or the reverse. A lock fault shows as a `req_take` for a foreign group in the first cycle that group is offered. The bench measures these windows cycle by cycle for each delay setting and flag pattern.

// File: rtl/spi_csq_pkg.sv
package spi_csq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_START,
        ST_XFER,
        ST_HOLD,
        ST_WAIT,
        ST_PARK
    } csq_state_e;

endpackage

// File: rtl/csq_delay.sv
module csq_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // every delay runs out before the next one is loaded
    assert_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0));

endmodule

// File: rtl/csq_gate.sv
module csq_gate #(
    parameter int GRP_W = 2,
    parameter int CSW   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [GRP_W-1:0] req_grp,
    input  logic [CSW-1:0]   req_cs,
    input  logic             req_lock,
    input  logic             req_hold,
    input  logic             open_idle,
    input  logic             open_park,
    input  logic [CSW-1:0]   park_cs,
    output logic             take,
    output logic             swap,
    output logic             lock_active,
    output logic [GRP_W-1:0] lock_owner
);
    logic             lock_q;
    logic [GRP_W-1:0] owner_q;
    logic             eligible;

    assign eligible = req_valid && (!lock_q || (req_grp == owner_q));
    assign take     = eligible && (open_idle || (open_park && (req_cs == park_cs)));
    assign swap     = eligible && open_park && (req_cs != park_cs);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            owner_q <= '0;
        end else if (take) begin
            lock_q  <= req_lock | req_hold;
            owner_q <= req_grp;
        end
    end

    assign lock_active = lock_q;
    assign lock_owner  = owner_q;

    assert_owner_moves_on_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_owner != $past(lock_owner)) |-> $past(take));

endmodule

// File: rtl/csq_decode.sv
module csq_decode #(
    parameter int NUM_CS = 4,
    parameter int CSW    = 2
) (
    input  logic [CSW-1:0]    code,
    input  logic              active,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = !(active && (code == CSW'(i)));
    end
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
    import spi_csq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int GRP_W  = 2,
    parameter int DLY_W  = 8,
    localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [GRP_W-1:0]  req_grp,
    input  logic [CSW-1:0]    req_cs,
    input  logic              req_hold,
    input  logic              req_wdel,
    input  logic              req_lock,
    output logic              req_take,
    output logic              sh_start,
    input  logic              sh_done,
    output logic [NUM_CS-1:0] cs_n,
    input  logic [DLY_W-1:0]  cfg_setup,
    input  logic [DLY_W-1:0]  cfg_hold,
    input  logic [DLY_W-1:0]  cfg_wait,
    output logic              lock_active,
    output logic [GRP_W-1:0]  lock_owner
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    csq_state_e       state_q, state_d;
    logic [CSW-1:0]   cur_cs;
    logic             cur_hold, cur_wdel;
    logic             take, swap, dly_end, dly_load, line_on;
    logic             use_setup, use_hold, use_wait;
    logic [DLY_W-1:0] dly_val;

    assign use_setup = (cfg_setup != '0);
    assign use_hold  = (cfg_hold != '0);
    assign use_wait  = cur_wdel && (cfg_wait != '0);

    csq_gate #(.GRP_W(GRP_W), .CSW(CSW)) u_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grp(req_grp),
        .req_cs(req_cs), .req_lock(req_lock), .req_hold(req_hold),
        .open_idle(state_q == ST_IDLE), .open_park(state_q == ST_PARK),
        .park_cs(cur_cs), .take(take), .swap(swap),
        .lock_active(lock_active), .lock_owner(lock_owner)
    );

    csq_delay #(.DLY_W(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
        .expired(dly_end)
    );

    csq_decode #(.NUM_CS(NUM_CS), .CSW(CSW)) u_decode (
        .code(cur_cs), .active(line_on), .cs_n(cs_n)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = use_setup ? ST_SETUP : ST_START;
            ST_SETUP: if (dly_end) state_d = ST_START;
            ST_START: state_d = ST_XFER;
            ST_XFER:
                if (sh_done) begin
                    if (cur_hold)      state_d = use_wait ? ST_WAIT : ST_PARK;
                    else if (use_hold) state_d = ST_HOLD;
                    else               state_d = use_wait ? ST_WAIT : ST_IDLE;
                end
            ST_HOLD:
                if (dly_end) state_d = (!cur_hold && use_wait) ? ST_WAIT : ST_IDLE;
            ST_WAIT:  if (dly_end) state_d = cur_hold ? ST_PARK : ST_IDLE;
            ST_PARK:
                if (take)      state_d = ST_START;
                else if (swap) state_d = use_hold ? ST_HOLD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and current-word fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_cs   <= '0;
            cur_hold <= 1'b0;
            cur_wdel <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cur_cs   <= req_cs;
                cur_hold <= req_hold;
                cur_wdel <= req_wdel;
            end
        end
    end

    // outputs and delay loading
    always_comb begin
        dly_load = (state_d != state_q) &&
                   (state_d == ST_SETUP || state_d == ST_HOLD || state_d == ST_WAIT);
        unique case (state_d)
            ST_SETUP: dly_val = cfg_setup - ONE;
            ST_HOLD:  dly_val = cfg_hold - ONE;
            ST_WAIT:  dly_val = cfg_wait - ONE;
            default:  dly_val = '0;
        endcase
        line_on  = (state_q != ST_IDLE) && !(state_q == ST_WAIT && !cur_hold);
        sh_start = (state_q == ST_START);
        req_take = take;
    end

    assert_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_start_under_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> (cs_n != '1));
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);
    assert_held_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && sh_done && cur_hold) |=> (cs_n == $past(cs_n)));
    assert_zero_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && sh_done && !cur_hold && cfg_hold == '0) |=> (cs_n == '1));

endmodule

// File: tb/test_spi_cs_sequencer.sv
`timescale 1ns/1ps
module test_spi_cs_sequencer;
    localparam int NCS = 4;
    localparam int GW  = 2;
    localparam int DW  = 8;
    localparam int NV  = 7;
    // columns: setup, hold, wait, hold1, wdel1, cs1, cs2, exp_setup1, exp_gap, exp_cslow, exp_setup2
    localparam int VEC [NV][11] = '{
        '{2, 3, 0, 0, 0, 1, 1, 2, 3, 3, 2},
        '{0, 0, 0, 0, 0, 2, 2, 0, 0, 0, 0},
        '{3, 2, 4, 0, 1, 0, 0, 3, 6, 2, 3},
        '{3, 2, 0, 1, 0, 1, 1, 3, 0, 0, 0},
        '{3, 2, 5, 1, 1, 3, 3, 3, 5, 5, 0},
        '{1, 4, 2, 1, 1, 1, 2, 1, 7, 7, 1},
        '{2, 5, 3, 0, 0, 0, 3, 2, 5, 5, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_hold = 1'b0, req_wdel = 1'b0, req_lock = 1'b0;
    logic [GW-1:0] req_grp = '0;
    logic [1:0] req_cs = '0;
    logic req_take, sh_start, lock_active;
    logic sh_done = 1'b0;
    logic [NCS-1:0] cs_n;
    logic [DW-1:0] cfg_setup = '0, cfg_hold = '0, cfg_wait = '0;
    logic [GW-1:0] lock_owner;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_cs_sequencer #(.NUM_CS(NCS), .GRP_W(GW), .DLY_W(DW)) i_spi_cs_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grp(req_grp),
        .req_cs(req_cs), .req_hold(req_hold), .req_wdel(req_wdel), .req_lock(req_lock),
        .req_take(req_take), .sh_start(sh_start), .sh_done(sh_done), .cs_n(cs_n),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_wait(cfg_wait),
        .lock_active(lock_active), .lock_owner(lock_owner)
    );

    function automatic logic [NCS-1:0] pat(int c);
        return ~(NCS'(1) << c);
    endfunction

    task automatic check(int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic offer(int grp, int cs, bit hold, bit wdel, bit lock);
        @(negedge clk);
        req_valid = 1'b1; req_grp = GW'(grp); req_cs = 2'(cs);
        req_hold = hold; req_wdel = wdel; req_lock = lock;
        #1;
    endtask

    // called right after a sample in which req_take was high
    task automatic run_setup(output int n, output logic [NCS-1:0] seen);
        n = 0;
        @(negedge clk); req_valid = 1'b0; #1;
        for (int k = 0; k < 300 && !sh_start; k++) begin
            if (cs_n != '1) n++;
            @(negedge clk); #1;
        end
        seen = cs_n;
    endtask

    // called at the sample where sh_start is high; returns at first sample after done edge
    task automatic finish_word();
        @(negedge clk);
        @(negedge clk); sh_done = 1'b1;
        @(negedge clk); sh_done = 1'b0; #1;
    endtask

    task automatic drain();
        for (int k = 0; k < 300 && cs_n != '1; k++) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s1, s2, gap, low;
        logic [NCS-1:0] seen;
        repeat (3) @(negedge clk);
        #1;
        check(int'(cs_n), int'({NCS{1'b1}}), "R1 cs_n after reset");
        check(int'(sh_start), 0, "R1 sh_start after reset");
        check(int'(lock_active), 0, "R1 lock_active after reset");
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(int'(req_take), 0, "R1 no take without request");

        // table walk: two words per vector
        for (int v = 0; v < NV; v++) begin
            cfg_setup = DW'(VEC[v][0]); cfg_hold = DW'(VEC[v][1]); cfg_wait = DW'(VEC[v][2]);
            offer(0, VEC[v][5], VEC[v][3] != 0, VEC[v][4] != 0, 1'b0);
            check(int'(req_take), 1, "R2 take from idle");
            run_setup(s1, seen);
            check(s1, VEC[v][7], "R2 R9 setup cycles before start");
            check(int'(seen), int'(pat(VEC[v][5])), "R2 selected line");
            finish_word();
            req_valid = 1'b1; req_grp = '0; req_cs = 2'(VEC[v][6]);
            req_hold = 1'b0; req_wdel = 1'b0; req_lock = 1'b0;
            #1;
            gap = 0; low = 0;
            for (int k = 0; k < 300 && !req_take; k++) begin
                gap++;
                if (cs_n != '1) low++;
                @(negedge clk); #1;
            end
            check(gap, VEC[v][8], "R3 R4 R5 R8 gap before next take");
            check(low, VEC[v][9], "R3 R4 R5 R8 line-low cycles in gap");
            run_setup(s2, seen);
            check(s2, VEC[v][10], "R4 R8 setup cycles of second word");
            check(int'(seen), int'(pat(VEC[v][6])), "R8 second word line");
            finish_word();
            drain();
        end

        // directed: lock without hold
        cfg_setup = '0; cfg_hold = '0; cfg_wait = '0;
        offer(0, 0, 1'b0, 1'b0, 1'b1);
        run_setup(s1, seen);
        finish_word();
        check(int'(cs_n), int'({NCS{1'b1}}), "R7 locked word releases line");
        check(int'(lock_active), 1, "R10 lock active after locked word");
        check(int'(lock_owner), 0, "R10 owner is group 0");
        offer(1, 2, 1'b0, 1'b0, 1'b0);
        low = 0;
        for (int k = 0; k < 5; k++) begin
            if (req_take || cs_n != '1) low++;
            @(negedge clk); #1;
        end
        check(low, 0, "R6 foreign group blocked while locked");
        req_grp = '0; req_cs = '0; #1;
        check(int'(req_take), 1, "R6 owner group taken");
        run_setup(s1, seen);
        finish_word();
        check(int'(lock_active), 0, "R10 lock cleared by unlocked word");
        offer(1, 2, 1'b0, 1'b0, 1'b0);
        check(int'(req_take), 1, "R6 other group accepted after unlock");
        run_setup(s1, seen);
        finish_word();
        drain();

        // directed: hold also blocks other groups
        offer(2, 3, 1'b1, 1'b0, 1'b0);
        run_setup(s1, seen);
        finish_word();
        check(int'(lock_owner), 2, "R10 owner is group 2");
        offer(1, 3, 1'b0, 1'b0, 1'b0);
        low = 0;
        for (int k = 0; k < 5; k++) begin
            if (req_take || cs_n != pat(3)) low++;
            @(negedge clk); #1;
        end
        check(low, 0, "R4 R6 held line kept, foreign group blocked");
        req_grp = 2'd2; #1;
        check(int'(req_take), 1, "R4 owner continues held sequence");
        run_setup(s1, seen);
        check(s1, 0, "R4 no setup after held word");
        finish_word();
        check(int'(cs_n), int'({NCS{1'b1}}), "R9 zero hold releases at once");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule